// File: doc/BRIEF.md
# Host Message Status Handshake

This block is the command and status side of a host management port. A host writes a command code into a message register. The block spends a fixed number of cycles on each accepted command. When a command completes, the block inverts a toggle bit. A host reads the toggle bit before it issues a command and waits until the value changes. Commands that arrive while the block is still processing are refused, and a busy flag shows when this is the case.

The status word has three bits. The first shows that the transmit buffer is free, and a transmit command clears it. The second shows that received packets are waiting. The third is the completion toggle. A depth-limited counter stands in for the receive queue: it counts packets that arrive from the network side. An acknowledge command removes one packet from that count. When the queue is full, further arrivals are dropped and tallied. Single-cycle strobes stand in for the network side: one for a packet arriving and one for a transmission finishing.

Top module: `host_msg_status`

## Requirements
- R1: After reset, the tx-ready bit is 1, and the rx-available bit, the toggle bit, the busy flag, the pending count and the drop count are all 0.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. Busy is then high for exactly PROC_CYCLES cycles. The toggle bit inverts once, on the edge PROC_CYCLES edges after the accepting edge, and busy drops on that same edge.
- R3: A command presented while busy is high is ignored. It causes no extra toggle and no transmit or receive effect.
- R4: Code 0x01 (transmit) clears the tx-ready bit on its accepting edge. The bit stays clear until a net_tx_sent strobe sets it again.
- R5: Each net_rx_arrive strobe while the queue is not full adds one to the pending count. The rx-available bit is set on the same edge.
- R6: Code 0x02 (acknowledge receipt) removes one pending packet on its completion edge. The rx-available bit stays high until the pending count reaches 0.
- R7: An arrival while the pending count equals RX_DEPTH is dropped. The count stays at RX_DEPTH and the drop count rises by one, saturating at its maximum.
- R8: An acknowledge issued with no pending packets still inverts the toggle bit, and the pending count stays 0.
- R9: Any other code only inverts the toggle bit. It does not touch the tx-ready bit or the pending count.
- R10: If an arrival coincides with an acknowledge completing on a full queue, the arrival is kept. The count stays at RX_DEPTH and nothing is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host writes a command this cycle |
| cmd_code | input | 8 | Command code (0x01 transmit, 0x02 acknowledge, others generic) |
| net_tx_sent | input | 1 | Strobe: pending transmission finished, buffer free |
| net_rx_arrive | input | 1 | Strobe: one packet arrived from the network |
| cmd_busy | output | 1 | A command is being processed |
| st_tx_ready | output | 1 | Transmit buffer free |
| st_rx_avail | output | 1 | At least one received packet pending |
| st_toggle | output | 1 | Inverts once per completed command |
| rx_pending | output | $clog2(RX_DEPTH+1) | Number of pending received packets |
| rx_dropped | output | DROP_W | Saturating count of dropped arrivals |

## Verification
A faulty processing counter shows up as a toggle that arrives a cycle early or late, or that arrives twice. The bench samples one cycle before the expected edge and again on it, so a mistimed toggle shows within PROC_CYCLES+1 cycles of the command. A wrong pending count shows on rx_pending and st_rx_avail in the cycle after the strobe or completion that caused it. A wrong transmit or drop decision shows up the same way. The full-queue case and the arrival that coincides with an acknowledge target the off-by-one faults in the counter's boundary logic.

// File: rtl/hmsg_pkg.sv
package hmsg_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] OP_XMIT  = 8'h01;
  localparam logic [CODE_W-1:0] OP_RXACK = 8'h02;

  typedef enum logic [1:0] {
    EFF_NONE  = 2'd0,
    EFF_XMIT  = 2'd1,
    EFF_RXACK = 2'd2
  } effect_t;

  function automatic effect_t decode_op(input logic [CODE_W-1:0] code);
    if (code == OP_XMIT)       return EFF_XMIT;
    else if (code == OP_RXACK) return EFF_RXACK;
    else                       return EFF_NONE;
  endfunction
endpackage

// File: rtl/msg_sequencer.sv
module msg_sequencer
  import hmsg_pkg::*;
#(
  parameter int PROC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              busy,
  output logic              toggle,
  output logic              start_xmit,
  output logic              ack_pop
);
  localparam int LAT_W = $clog2(PROC_CYCLES + 1);

  logic [LAT_W-1:0] remain;
  effect_t          held_eff;
  logic             accept;
  logic             finish;

  assign accept     = cmd_valid && !busy;
  assign finish     = busy && (remain == '0);
  assign start_xmit = accept && (decode_op(cmd_code) == EFF_XMIT);
  assign ack_pop    = finish && (held_eff == EFF_RXACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      toggle   <= 1'b0;
      remain   <= '0;
      held_eff <= EFF_NONE;
    end else if (accept) begin
      busy     <= 1'b1;
      remain   <= LAT_W'(PROC_CYCLES - 1);
      held_eff <= decode_op(cmd_code);
    end else if (finish) begin
      busy     <= 1'b0;
      toggle   <= ~toggle;
      held_eff <= EFF_NONE;
    end else if (busy) begin
      remain   <= remain - LAT_W'(1);
    end
  end
endmodule

// File: rtl/tx_ready_flag.sv
module tx_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic start_xmit,
  input  logic sent,
  output logic ready
);
  always_ff @(posedge clk) begin
    if (rst)             ready <= 1'b1;
    else if (start_xmit) ready <= 1'b0;
    else if (sent)       ready <= 1'b1;
  end
endmodule

// File: rtl/rx_queue_track.sv
module rx_queue_track #(
  parameter int RX_DEPTH = 4,
  parameter int DROP_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          arrive,
  input  logic                          pop,
  output logic [$clog2(RX_DEPTH+1)-1:0] count,
  output logic                          avail,
  output logic [DROP_W-1:0]             dropped
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(RX_DEPTH);

  logic             do_pop;
  logic             room;
  logic             take;
  logic [CNT_W-1:0] nxt;

  assign do_pop = pop && (count != '0);
  assign room   = (count != FULL_C) || do_pop;
  assign take   = arrive && room;

  always_comb begin
    nxt = count;
    if (do_pop) nxt = nxt - CNT_W'(1);
    if (take)   nxt = nxt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      avail   <= 1'b0;
      dropped <= '0;
    end else begin
      count <= nxt;
      avail <= (nxt != '0);
      if (arrive && !room && (dropped != '1))
        dropped <= dropped + DROP_W'(1);
    end
  end
endmodule

// File: rtl/host_msg_status.sv
module host_msg_status
  import hmsg_pkg::*;
#(
  parameter int PROC_CYCLES = 4,
  parameter int RX_DEPTH    = 4,
  parameter int DROP_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_valid,
  input  logic [7:0]                    cmd_code,
  input  logic                          net_tx_sent,
  input  logic                          net_rx_arrive,
  output logic                          cmd_busy,
  output logic                          st_tx_ready,
  output logic                          st_rx_avail,
  output logic                          st_toggle,
  output logic [$clog2(RX_DEPTH+1)-1:0] rx_pending,
  output logic [DROP_W-1:0]             rx_dropped
);
  logic start_xmit;
  logic ack_pop;

  msg_sequencer #(.PROC_CYCLES(PROC_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .busy       (cmd_busy),
    .toggle     (st_toggle),
    .start_xmit (start_xmit),
    .ack_pop    (ack_pop)
  );

  tx_ready_flag u_tx (
    .clk        (clk),
    .rst        (rst),
    .start_xmit (start_xmit),
    .sent       (net_tx_sent),
    .ready      (st_tx_ready)
  );

  rx_queue_track #(.RX_DEPTH(RX_DEPTH), .DROP_W(DROP_W)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .arrive  (net_rx_arrive),
    .pop     (ack_pop),
    .count   (rx_pending),
    .avail   (st_rx_avail),
    .dropped (rx_dropped)
  );
endmodule

// File: rtl/hmsg_checker.sv
module hmsg_checker #(
  parameter int RX_DEPTH = 4,
  parameter int DROP_W   = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cmd_valid,
  input logic [7:0]                    cmd_code,
  input logic                          cmd_busy,
  input logic                          st_tx_ready,
  input logic                          st_rx_avail,
  input logic                          st_toggle,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_pending,
  input logic [DROP_W-1:0]             rx_dropped
);
  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_busy) |=> cmd_busy);

  // R2
  toggle_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_toggle) |-> $fell(cmd_busy));

  // R4
  xmit_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_busy && cmd_code == 8'h01) |=> !st_tx_ready);

  // R6
  avail_matches_count_chk: assert property (@(posedge clk) disable iff (rst)
    st_rx_avail == (rx_pending != '0));

  // R7
  pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pending <= ($clog2(RX_DEPTH+1))'(RX_DEPTH));

  // R7
  drop_only_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_dropped) |-> (rx_pending == ($clog2(RX_DEPTH+1))'(RX_DEPTH)));
endmodule

bind host_msg_status hmsg_checker #(.RX_DEPTH(RX_DEPTH), .DROP_W(DROP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_busy    (cmd_busy),
  .st_tx_ready (st_tx_ready),
  .st_rx_avail (st_rx_avail),
  .st_toggle   (st_toggle),
  .rx_pending  (rx_pending),
  .rx_dropped  (rx_dropped)
);

// File: tb/tb_host_msg_status.sv
`timescale 1ns/1ps
module tb_host_msg_status;
  localparam int LAT   = 4;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic net_tx_sent = 1'b0;
  logic net_rx_arrive = 1'b0;
  logic cmd_busy, st_tx_ready, st_rx_avail, st_toggle;
  logic [CW-1:0] rx_pending;
  logic [DW-1:0] rx_dropped;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  host_msg_status #(.PROC_CYCLES(LAT), .RX_DEPTH(DEPTH), .DROP_W(DW)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .net_tx_sent(net_tx_sent), .net_rx_arrive(net_rx_arrive),
    .cmd_busy(cmd_busy), .st_tx_ready(st_tx_ready), .st_rx_avail(st_rx_avail),
    .st_toggle(st_toggle), .rx_pending(rx_pending), .rx_dropped(rx_dropped)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // present for one cycle; returns at the negedge after the accepting edge
  task automatic send(input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_wait();
    repeat (LAT) @(negedge clk);
  endtask

  task automatic arrive_one();
    @(negedge clk);
    net_rx_arrive = 1'b1;
    @(negedge clk);
    net_rx_arrive = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 tx_ready", st_tx_ready, 1);
    check("R1 rx_avail", st_rx_avail, 0);
    check("R1 toggle", st_toggle, 0);
    check("R1 busy", cmd_busy, 0);
    check("R1 pending", rx_pending, 0);
    check("R1 dropped", rx_dropped, 0);
  endtask

  task automatic t_generic();
    logic t0;
    t0 = st_toggle;
    send(8'h33);
    check("R2 busy after accept", cmd_busy, 1);
    repeat (LAT-1) @(negedge clk);
    check("R2 toggle not early", st_toggle, t0);
    check("R2 busy held", cmd_busy, 1);
    @(negedge clk);
    check("R2 toggle on time", st_toggle, !t0);
    check("R2 busy released", cmd_busy, 0);
    check("R9 tx untouched", st_tx_ready, 1);
    check("R9 pending untouched", rx_pending, 0);
  endtask

  task automatic t_busy_hold();
    logic t0;
    t0 = st_toggle;
    send(8'h44);
    cmd_valid = 1'b1;
    cmd_code  = 8'h01;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (LAT-1) @(negedge clk);
    check("R3 one toggle", st_toggle, !t0);
    check("R3 no xmit effect", st_tx_ready, 1);
    repeat (LAT+2) @(negedge clk);
    check("R3 no second toggle", st_toggle, !t0);
  endtask

  task automatic t_xmit();
    send(8'h01);
    check("R4 cleared on accept", st_tx_ready, 0);
    finish_wait();
    check("R4 still clear", st_tx_ready, 0);
    @(negedge clk);
    net_tx_sent = 1'b1;
    @(negedge clk);
    net_tx_sent = 1'b0;
    check("R4 set by sent", st_tx_ready, 1);
  endtask

  task automatic t_rx();
    for (int i = 1; i <= 3; i++) begin
      arrive_one();
      check("R5 count", rx_pending, i);
      check("R5 avail", st_rx_avail, 1);
    end
    for (int i = 2; i >= 0; i--) begin
      send(8'h02);
      finish_wait();
      check("R6 count", rx_pending, i);
      check("R6 avail", st_rx_avail, (i != 0) ? 1 : 0);
    end
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH + 2; i++) arrive_one();
    check("R7 count capped", rx_pending, DEPTH);
    check("R7 drops", rx_dropped, 2);
  endtask

  task automatic t_coincide();
    send(8'h02);
    repeat (LAT-1) @(negedge clk);
    net_rx_arrive = 1'b1;
    @(negedge clk);
    net_rx_arrive = 1'b0;
    check("R10 count kept", rx_pending, DEPTH);
    check("R10 no drop", rx_dropped, 2);
  endtask

  task automatic t_empty_ack();
    logic t0;
    for (int i = 0; i < DEPTH; i++) begin
      send(8'h02);
      finish_wait();
    end
    check("R6 drained", rx_pending, 0);
    t0 = st_toggle;
    send(8'h02);
    finish_wait();
    check("R8 toggles", st_toggle, !t0);
    check("R8 count zero", rx_pending, 0);
    check("R8 avail low", st_rx_avail, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_generic();
    t_busy_hold();
    t_xmit();
    t_rx();
    t_overflow();
    t_coincide();
    t_empty_ack();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule